// File: doc/BRIEF.md
# Block Compare Search Step Unit

This unit carries out one step of a compare-and-scan instruction of an 8-bit processor core. The core supplies the accumulator, a 16-bit address pointer, a 16-bit byte counter, its current flag byte, a direction choice and a repeat choice, and then pulses `start`. The unit fetches one byte at the pointer over a request/acknowledge read port. It subtracts that byte from the accumulator and keeps the difference only to form flags. It then returns the stepped pointer, the decremented counter, the new flag byte, a rewind indication and the cycle cost of the step. It never writes memory.

When repeat is selected, the core re-executes the instruction while `rewind` is high. `rewind` goes high only when the counter has not run out and the byte did not match. Decoding, the program counter and the register file stay in the core.

Flag byte layout (both input and output): bit 7 sign, bit 6 zero, bit 5 undocumented copy Y, bit 4 half-borrow, bit 3 undocumented copy X, bit 2 parity/overflow, bit 1 subtract, bit 0 carry.

Top module: `cmp_search_step`

## Requirements
- R1: A `start` pulse while idle raises `mem_req` on the next cycle with `mem_addr` equal to the sampled `ptr_in`. Both hold unchanged until a cycle with `mem_ack` high.
- R2: `ptr_out` is the pointer plus one when `dir_down` is 0 and minus one when it is 1, wrapping modulo 2^16.
- R3: `cnt_out` is the counter minus one, wrapping from 0x0000 to 0xFFFF.
- R4: Output flag bit 1 (subtract) is always 1. Bit 0 (carry) equals bit 0 of `flags_in`. No other `flags_in` bit affects the result.
- R5: Output bit 6 (zero) is set when accumulator minus fetched byte is 0 modulo 256. Bit 7 (sign) is bit 7 of that difference.
- R6: Output bit 4 (half-borrow) is set when the low nibble of the accumulator is less than the low nibble of the fetched byte.
- R7: Let the adjusted value be the difference minus the half-borrow bit. Output bit 3 is adjusted bit 3, and output bit 5 is adjusted bit 1.
- R8: Output bit 2 (parity/overflow) is set when the decremented counter is non-zero.
- R9: `rewind` is 1 only when `repeat_en` was set at start, bit 2 is set and bit 6 is clear.
- R10: `cycles_out` is 16 for a step without rewind and 21 for a step with rewind.
- R11: `done` is a single-cycle pulse in the cycle after the acknowledging edge. All result outputs hold their values until the next `done`.
- R12: A `start` pulse while a fetch is pending is ignored: the address and the later results belong to the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one step (sampled only when idle) |
| acc | input | 8 | Accumulator value |
| ptr_in | input | ADDR_W | Address pointer |
| cnt_in | input | CNT_W | Byte counter |
| flags_in | input | 8 | Current flag byte |
| dir_down | input | 1 | 0: pointer increments, 1: pointer decrements |
| repeat_en | input | 1 | Repeating form of the instruction |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Read address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 8 | Read data |
| busy | output | 1 | Fetch pending |
| done | output | 1 | Result valid pulse |
| ptr_out | output | ADDR_W | Stepped pointer |
| cnt_out | output | CNT_W | Decremented counter |
| flags_out | output | 8 | New flag byte |
| rewind | output | 1 | Re-execute request |
| cycles_out | output | CYC_W | Cycle cost of this step |

## Verification
The checker covers on every cycle the handshake (request and address held until acknowledge), the single-cycle `done` that follows each acknowledge, the subtract flag, the agreement of `rewind` with the overflow and zero bits, and the cycle cost that `rewind` selects. Only the bench's scenarios can show the arithmetic: the difference flags, the half-borrow, and the undocumented bits taken from the adjusted value, including a case where the adjustment flips bit 3. The same holds for pointer and counter wrap at both ends, carry pass-through, and a stray `start` while a fetch waits.

// File: rtl/cmp_search_pkg.sv
package cmp_search_pkg;
  typedef logic [7:0] byte_t;

  localparam int FL_SIGN = 7;
  localparam int FL_ZERO = 6;
  localparam int FL_Y    = 5;
  localparam int FL_HALF = 4;
  localparam int FL_X    = 3;
  localparam int FL_PV   = 2;
  localparam int FL_SUB  = 1;
  localparam int FL_CARRY = 0;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_FETCH = 1'b1} fetch_state_e;
endpackage

// File: rtl/cmp_search_fetch.sv
module cmp_search_fetch
  import cmp_search_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  byte_t             acc,
  input  logic [ADDR_W-1:0] ptr_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              carry_in,
  input  logic              dir_down,
  input  logic              repeat_en,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              busy,
  output logic              capture,
  output byte_t             op_acc,
  output logic [CNT_W-1:0]  op_cnt,
  output logic              op_carry,
  output logic              op_dir,
  output logic              op_rep
);
  fetch_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mem_addr <= '0;
      op_acc   <= '0;
      op_cnt   <= '0;
      op_carry <= 1'b0;
      op_dir   <= 1'b0;
      op_rep   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_FETCH;
          mem_addr <= ptr_in;
          op_acc   <= acc;
          op_cnt   <= cnt_in;
          op_carry <= carry_in;
          op_dir   <= dir_down;
          op_rep   <= repeat_en;
        end
        ST_FETCH: if (mem_ack) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state == ST_FETCH);
  assign mem_req = busy;
  assign capture = busy && mem_ack;
endmodule

// File: rtl/cmp_search_step_unit.sv
module cmp_search_step_unit #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              dir_down,
  output logic [ADDR_W-1:0] ptr_next,
  output logic [CNT_W-1:0]  cnt_next,
  output logic              cnt_live
);
  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  ONE_C = CNT_W'(1);

  always_comb begin
    ptr_next = dir_down ? (ptr - ONE_A) : (ptr + ONE_A);
    cnt_next = cnt - ONE_C;
    cnt_live = |cnt_next;
  end
endmodule

// File: rtl/cmp_search_flags.sv
module cmp_search_flags
  import cmp_search_pkg::*;
(
  input  byte_t acc,
  input  byte_t data,
  input  logic  carry_in,
  input  logic  cnt_live,
  input  logic  repeat_en,
  output byte_t flags,
  output logic  rewind
);
  byte_t diff;
  byte_t adj;
  logic  half;

  always_comb begin
    diff = acc - data;
    half = (acc[3:0] < data[3:0]);
    adj  = diff - byte_t'(half);
    flags           = '0;
    flags[FL_SIGN]  = diff[7];
    flags[FL_ZERO]  = (diff == 8'h00);
    flags[FL_Y]     = adj[1];
    flags[FL_HALF]  = half;
    flags[FL_X]     = adj[3];
    flags[FL_PV]    = cnt_live;
    flags[FL_SUB]   = 1'b1;
    flags[FL_CARRY] = carry_in;
    rewind = repeat_en && cnt_live && (diff != 8'h00);
  end
endmodule

// File: rtl/cmp_search_step.sv
module cmp_search_step
  import cmp_search_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 16,
  parameter int CYC_W    = 6,
  parameter int BASE_CYC = 16,
  parameter int RPT_CYC  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        acc,
  input  logic [ADDR_W-1:0] ptr_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [7:0]        flags_in,
  input  logic              dir_down,
  input  logic              repeat_en,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] ptr_out,
  output logic [CNT_W-1:0]  cnt_out,
  output logic [7:0]        flags_out,
  output logic              rewind,
  output logic [CYC_W-1:0]  cycles_out
);
  localparam logic [CYC_W-1:0] COST_ONE = CYC_W'(BASE_CYC);
  localparam logic [CYC_W-1:0] COST_RPT = CYC_W'(BASE_CYC + RPT_CYC);

  logic              capture;
  byte_t             op_acc;
  logic [CNT_W-1:0]  op_cnt;
  logic              op_carry, op_dir, op_rep;
  logic [ADDR_W-1:0] ptr_nx;
  logic [CNT_W-1:0]  cnt_nx;
  logic              cnt_live;
  byte_t             flags_nx;
  logic              rewind_nx;

  cmp_search_fetch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fetch (
    .clk(clk), .rst(rst), .start(start), .acc(acc), .ptr_in(ptr_in),
    .cnt_in(cnt_in), .carry_in(flags_in[FL_CARRY]), .dir_down(dir_down),
    .repeat_en(repeat_en), .mem_ack(mem_ack), .mem_req(mem_req),
    .mem_addr(mem_addr), .busy(busy), .capture(capture), .op_acc(op_acc),
    .op_cnt(op_cnt), .op_carry(op_carry), .op_dir(op_dir), .op_rep(op_rep)
  );

  cmp_search_step_unit #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_step (
    .ptr(mem_addr), .cnt(op_cnt), .dir_down(op_dir),
    .ptr_next(ptr_nx), .cnt_next(cnt_nx), .cnt_live(cnt_live)
  );

  cmp_search_flags u_flags (
    .acc(op_acc), .data(mem_rdata), .carry_in(op_carry), .cnt_live(cnt_live),
    .repeat_en(op_rep), .flags(flags_nx), .rewind(rewind_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      ptr_out    <= '0;
      cnt_out    <= '0;
      flags_out  <= '0;
      rewind     <= 1'b0;
      cycles_out <= '0;
    end else begin
      done <= capture;
      if (capture) begin
        ptr_out    <= ptr_nx;
        cnt_out    <= cnt_nx;
        flags_out  <= flags_nx;
        rewind     <= rewind_nx;
        cycles_out <= rewind_nx ? COST_RPT : COST_ONE;
      end
    end
  end
endmodule

// File: rtl/cmp_search_step_chk.sv
module cmp_search_step_chk #(
  parameter int ADDR_W   = 16,
  parameter int CYC_W    = 6,
  parameter int BASE_CYC = 16,
  parameter int RPT_CYC  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy,
  input logic              done,
  input logic [7:0]        flags_out,
  input logic              rewind,
  input logic [CYC_W-1:0]  cycles_out
);
  assert_req_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_busy_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (busy && !mem_ack) |=> busy);

  assert_done_follows_ack_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> done);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_sub_flag_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> flags_out[1]);

  assert_rewind_flags_R9: assert property (@(posedge clk) disable iff (rst)
    (done && rewind) |-> (flags_out[2] && !flags_out[6]));

  assert_cycle_cost_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (cycles_out == (rewind ? CYC_W'(BASE_CYC + RPT_CYC) : CYC_W'(BASE_CYC))));
endmodule

bind cmp_search_step cmp_search_step_chk #(
  .ADDR_W(ADDR_W), .CYC_W(CYC_W), .BASE_CYC(BASE_CYC), .RPT_CYC(RPT_CYC)
) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .busy(busy), .done(done), .flags_out(flags_out),
  .rewind(rewind), .cycles_out(cycles_out)
);

// File: tb/cmp_search_step_tb.sv
module cmp_search_step_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [7:0]  acc;
  logic [15:0] ptr_in;
  logic [15:0] cnt_in;
  logic [7:0]  flags_in;
  logic        dir_down, repeat_en;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ack;
  logic [7:0]  mem_rdata;
  logic        busy, done;
  logic [15:0] ptr_out, cnt_out;
  logic [7:0]  flags_out;
  logic        rewind;
  logic [5:0]  cycles_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cmp_search_step u_dut (
    .clk(clk), .rst(rst), .start(start), .acc(acc), .ptr_in(ptr_in),
    .cnt_in(cnt_in), .flags_in(flags_in), .dir_down(dir_down),
    .repeat_en(repeat_en), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .ptr_out(ptr_out), .cnt_out(cnt_out), .flags_out(flags_out),
    .rewind(rewind), .cycles_out(cycles_out)
  );

  typedef struct packed {
    logic [7:0]  a;
    logic [7:0]  d;
    logic [15:0] c;
    logic [7:0]  f;
    logic        dn;
    logic        rp;
    logic [15:0] p;
    logic [7:0]  ef;
    logic        er;
    logic [15:0] ep;
    logic [15:0] ec;
  } vec_t;

  // flags: 7 S, 6 Z, 5 Y, 4 H, 3 X, 2 PV, 1 N, 0 C
  localparam vec_t VT [8] = '{
    '{8'h42, 8'h42, 16'h0005, 8'h00, 1'b0, 1'b1, 16'h1000, 8'h46, 1'b0, 16'h1001, 16'h0004},
    '{8'h50, 8'h21, 16'h0003, 8'h01, 1'b1, 1'b1, 16'h2000, 8'h3F, 1'b1, 16'h1FFF, 16'h0002},
    '{8'h10, 8'h20, 16'h0001, 8'hFF, 1'b0, 1'b1, 16'hFFFF, 8'h83, 1'b0, 16'h0000, 16'h0000},
    '{8'h0A, 8'h00, 16'h0000, 8'hFE, 1'b1, 1'b0, 16'h0000, 8'h2E, 1'b0, 16'hFFFF, 16'hFFFF},
    '{8'h00, 8'h01, 16'h0100, 8'h00, 1'b0, 1'b1, 16'h3000, 8'hBE, 1'b1, 16'h3001, 16'h00FF},
    '{8'h38, 8'h38, 16'h0001, 8'h01, 1'b1, 1'b1, 16'h4000, 8'h43, 1'b0, 16'h3FFF, 16'h0000},
    '{8'h13, 8'h05, 16'h0010, 8'h00, 1'b0, 1'b0, 16'h5000, 8'h1E, 1'b0, 16'h5001, 16'h000F},
    '{8'h10, 8'h08, 16'h0002, 8'h00, 1'b0, 1'b1, 16'h6000, 8'h36, 1'b1, 16'h6001, 16'h0001}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk);
    acc = v.a; mem_rdata = v.d; cnt_in = v.c; flags_in = v.f;
    dir_down = v.dn; repeat_en = v.rp; ptr_in = v.p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_fetch(input int wait_cyc, input logic [7:0] data);
    for (int i = 0; i < wait_cyc; i++) @(negedge clk);
    mem_rdata = data; mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; mem_ack = 1'b0; mem_rdata = '0;
    acc = '0; ptr_in = '0; cnt_in = '0; flags_in = '0; dir_down = 1'b0; repeat_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!done && !mem_req && !busy && flags_out == 8'h00, "R11 reset state",
          {done, mem_req, busy, flags_out}, 32'h0);

    foreach (VT[k]) begin
      issue(VT[k]);
      check(mem_req && mem_addr == VT[k].p, "R1 request address", {mem_req, mem_addr}, {1'b1, VT[k].p});
      acc = 8'hEE; ptr_in = 16'hDEAD; flags_in = ~VT[k].f;
      finish_fetch(k % 3, VT[k].d);
      check(done, "R11 done after ack", done, 1);
      check(ptr_out == VT[k].ep, "R2 pointer step", ptr_out, VT[k].ep);
      check(cnt_out == VT[k].ec, "R3 counter decrement", cnt_out, VT[k].ec);
      check(flags_out == VT[k].ef, "R4 R5 R6 R7 R8 flag byte", flags_out, VT[k].ef);
      check(rewind == VT[k].er, "R9 rewind", rewind, VT[k].er);
      check(cycles_out == (VT[k].er ? 6'd21 : 6'd16), "R10 cycle cost",
            cycles_out, VT[k].er ? 21 : 16);
      @(negedge clk);
      check(!done && flags_out == VT[k].ef, "R11 pulse and hold", {done, flags_out}, VT[k].ef);
    end

    // R12: stray start while pending
    issue(VT[1]);
    @(negedge clk);
    start = 1'b1; ptr_in = 16'h7777; acc = 8'h00; repeat_en = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check(mem_addr == 16'h2000, "R12 address kept", mem_addr, 16'h2000);
    finish_fetch(1, 8'h21);
    check(flags_out == 8'h3F && rewind && ptr_out == 16'h1FFF, "R12 results of first request",
          {flags_out, rewind, ptr_out}, {8'h3F, 1'b1, 16'h1FFF});
    @(negedge clk);
    check(!mem_req && !busy, "R12 no second fetch", {mem_req, busy}, 0);

    // R4: only carry of flags_in passes
    issue('{8'h42, 8'h42, 16'h0005, 8'hFE, 1'b0, 1'b0, 16'h1000, 8'h46, 1'b0, 16'h1001, 16'h0004});
    finish_fetch(0, 8'h42);
    check(flags_out == 8'h46, "R4 input flags other than carry ignored", flags_out, 8'h46);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule